// File: doc/BRIEF.md
# Sleep Wake-Up Sequencing Controller

This block is the sleep-exit path of a small processor core. The core signals that it is executing a sleep instruction and passes the address of that instruction. The block then stops issuing instruction fetches and waits for a rising edge on an external interrupt input. The edge sets an interrupt flag. The block then holds the core stalled while the oscillator starts up, but only in crystal-type clock modes. After that it restarts fetching.

There are two ways to restart. If the global interrupt enable is set, the block discards the instruction that was prefetched before sleep and issues a dummy slot in its place. It then fetches from the high-priority vector address and clears the enable. If the global interrupt enable is clear, fetching continues in-line with the word after the already-fetched one.

One clock of the block is one oscillator period, and one instruction cycle lasts four clocks. The start-up counter therefore counts oscillator periods directly.

Top module: `slpw_wake_ctrl`

## Requirements
- R1: A rising edge on `int_pin` (low in one clock, high in the next) sets `int_flag`, and the flag is visible one clock after the clock that sampled the high level. The flag stays set until `flag_clr` is applied. A new edge in the same clock as `flag_clr` wins, so the flag stays set.
- R2: In crystal-type modes (`osc_mode` 00, 01 or 10), the first post-wake slot appears OST_LEN + 4 clocks after the clock that sampled the wake edge. Here a slot means a `fetch_valid` pulse or a `flush` pulse. `core_halt` stays 1 until OST_LEN clocks after that clock.
- R3: In the external-clock / RC mode (`osc_mode` 11), the start-up wait is skipped and the first post-wake slot appears 4 clocks after the wake edge.
- R4: If `gie` is 1 at wake-up, the first slot is a one-clock `flush` pulse with `fetch_valid` low. It is followed four clocks later by a fetch of VEC_ADDR (default 0x0008), and four clocks after that by a fetch of VEC_ADDR + 2.
- R5: If `gie` is 0 at wake-up, no flush is issued. The first slot fetches `pc_in` + 4, where `pc_in` is the address of the sleep instruction, and the next slot fetches `pc_in` + 6.
- R6: Taking the vector clears `gie` in the clock of the wake transition. The in-line path leaves `gie` unchanged.
- R7: While running, `fetch_valid` pulses for exactly one clock in every four, and each fetch address is 2 above the one before it.
- R8: `sleep_req` is ignored when `int_flag` is already set, or when an interrupt edge is sampled in the same clock. In that case `core_halt` stays 0 and fetching continues. An interrupt edge while running does not stall the core.
- R9: A sleep request that is accepted raises `core_halt` one clock later. From the second stalled clock onward, neither `fetch_valid` nor `flush` is asserted until the wake sequence completes.
- R10: A write strobe `gie_we` loads `gie_wdata` into `gie`, visible one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one period per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Core is executing a sleep instruction |
| pc_in | input | AW | Address of the sleep instruction |
| int_pin | input | 1 | External interrupt input, rising edge active |
| osc_mode | input | 2 | 00/01/10 crystal-type, 11 external clock or RC |
| gie_we | input | 1 | Write strobe for the global interrupt enable |
| gie_wdata | input | 1 | Value written to the global interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| fetch_valid | output | 1 | One-clock fetch strobe |
| fetch_addr | output | AW | Address of the current fetch |
| flush | output | 1 | Dummy slot replacing the discarded prefetch |
| int_flag | output | 1 | Interrupt flag |
| gie | output | 1 | Global interrupt enable |
| core_halt | output | 1 | Core is asleep or waiting for the oscillator |

## Verification
The interrupt flag and the enable are due one clock after their causing edge. `core_halt` rises one clock after an accepted sleep request. The first post-wake slot is due exactly 4 clocks after the wake edge, or OST_LEN + 4 clocks in crystal modes, and later slots come 4 clocks apart. The bench drives every input on the falling edge and samples on the falling edge after a counted number of rising edges. Each result is checked in the clock where it is due, and every earlier clock of the wait window is also checked to show that nothing arrived early.

// File: rtl/slpw_pkg.sv
package slpw_pkg;

    typedef enum logic [1:0] {
        OSC_LP  = 2'b00,
        OSC_XT  = 2'b01,
        OSC_HS  = 2'b10,
        OSC_EXT = 2'b11
    } osc_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_OST   = 2'b10
    } core_st_e;

    // crystal-type oscillators need a start-up wait before the core resumes
    function automatic logic osc_needs_startup(input osc_mode_e m);
        return (m != OSC_EXT);
    endfunction

endpackage

// File: rtl/slpw_edge_det.sv
module slpw_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign rise = pin & ~pin_q;

    // an edge is reported in a single clock only
    p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/slpw_ost_timer.sv
module slpw_ost_timer #(
    parameter int unsigned LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s r_d, r_q;

    assign done = r_q.run && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.run = 1'b1;
            r_d.cnt = '0;
        end else if (r_q.run) begin
            if (done) begin
                r_d.run = 1'b0;
                r_d.cnt = '0;
            end else begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.run |-> (r_q.cnt <= LAST));

    p_done_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

endmodule

// File: rtl/slpw_fetch_seq.sv
module slpw_fetch_seq #(
    parameter int unsigned AW  = 16,
    parameter int unsigned QPI = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_dummy,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic          flush
);
    localparam int unsigned QW = (QPI > 1) ? $clog2(QPI) : 1;
    localparam logic [QW-1:0] QLAST = QW'(QPI - 1);
    localparam logic [AW-1:0] WORD_STEP = AW'(2);

    typedef struct packed {
        logic [QW-1:0] qcnt;
        logic [AW-1:0] pc;
        logic          dpend;
        logic          fv;
        logic [AW-1:0] fa;
        logic          fl;
    } seq_s;

    seq_s r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.fv = 1'b0;
        r_d.fl = 1'b0;
        if (load) begin
            r_d.pc    = load_addr;
            r_d.dpend = load_dummy;
            r_d.qcnt  = '0;
        end else if (!halt) begin
            if (r_q.qcnt == QLAST) begin
                r_d.qcnt = '0;
                if (r_q.dpend) begin
                    r_d.fl    = 1'b1;
                    r_d.dpend = 1'b0;
                end else begin
                    r_d.fv = 1'b1;
                    r_d.fa = r_q.pc;
                    r_d.pc = r_q.pc + WORD_STEP;
                end
            end else begin
                r_d.qcnt = r_q.qcnt + QW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign fetch_valid = r_q.fv;
    assign fetch_addr  = r_q.fa;
    assign flush       = r_q.fl;

    p_slot_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid || flush) |=> !(fetch_valid || flush));

    p_flush_no_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !fetch_valid);

endmodule

// File: rtl/slpw_wake_ctrl.sv
module slpw_wake_ctrl #(
    parameter int unsigned   AW       = 16,
    parameter int unsigned   OST_LEN  = 1024,
    parameter int unsigned   QPI      = 4,
    parameter logic [AW-1:0] VEC_ADDR = AW'(8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic [AW-1:0] pc_in,
    input  logic          int_pin,
    input  logic [1:0]    osc_mode,
    input  logic          gie_we,
    input  logic          gie_wdata,
    input  logic          flag_clr,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic          flush,
    output logic          int_flag,
    output logic          gie,
    output logic          core_halt
);
    import slpw_pkg::*;

    localparam logic [AW-1:0] RESUME_OFS = AW'(4);

    typedef struct packed {
        core_st_e      st;
        logic          flag;
        logic          gie;
        logic [AW-1:0] ret_pc;
    } ctl_s;

    ctl_s          r_d, r_q;
    logic          pin_rise;
    logic          tmr_start, tmr_done;
    logic          wake_now;
    logic          seq_load, seq_dummy;
    logic [AW-1:0] seq_addr;

    slpw_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (int_pin),
        .rise  (pin_rise)
    );

    slpw_ost_timer #(.LEN(OST_LEN)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    slpw_fetch_seq #(.AW(AW), .QPI(QPI)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt        (core_halt),
        .load        (seq_load),
        .load_addr   (seq_addr),
        .load_dummy  (seq_dummy),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .flush       (flush)
    );

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        wake_now  = 1'b0;
        seq_load  = 1'b0;
        seq_dummy = 1'b0;
        seq_addr  = r_q.ret_pc;

        unique case (r_q.st)
            ST_RUN: begin
                if (sleep_req && !r_q.flag && !pin_rise) begin
                    r_d.st     = ST_SLEEP;
                    r_d.ret_pc = pc_in + RESUME_OFS;
                end
            end
            ST_SLEEP: begin
                if (pin_rise) begin
                    if (osc_needs_startup(osc_mode_e'(osc_mode))) begin
                        r_d.st    = ST_OST;
                        tmr_start = 1'b1;
                    end else begin
                        wake_now = 1'b1;
                    end
                end
            end
            ST_OST: begin
                if (tmr_done) wake_now = 1'b1;
            end
            default: r_d.st = ST_RUN;
        endcase

        if (gie_we) r_d.gie = gie_wdata;

        if (wake_now) begin
            r_d.st   = ST_RUN;
            seq_load = 1'b1;
            if (r_q.gie) begin
                seq_addr  = VEC_ADDR;
                seq_dummy = 1'b1;
                r_d.gie   = 1'b0;
            end
        end

        if (pin_rise)      r_d.flag = 1'b1;
        else if (flag_clr) r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_RUN;
            r_q.flag   <= 1'b0;
            r_q.gie    <= 1'b0;
            r_q.ret_pc <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign int_flag  = r_q.flag;
    assign gie       = r_q.gie;
    assign core_halt = (r_q.st != ST_RUN);

    p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> int_flag);

    p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag && !flag_clr) |=> int_flag);

    p_xtal_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP && pin_rise && osc_mode != 2'b11) |=> (r_q.st == ST_OST));

    p_ext_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP && pin_rise && osc_mode == 2'b11) |=> (r_q.st == ST_RUN));

    p_vec_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_now && gie) |=> !gie);

    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && sleep_req && (int_flag || pin_rise)) |=> !core_halt);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_halt && $past(core_halt)) |-> (!fetch_valid && !flush));

    p_gie_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_we && !wake_now) |=> (gie == $past(gie_wdata)));

endmodule

// File: tb/slpw_wake_ctrl_tb_top.sv
module slpw_wake_ctrl_tb_top;

    localparam int unsigned AW  = 16;
    localparam int unsigned OST = 1024;
    localparam int          NV  = 6;

    // vector: {osc_mode[1:0], gie, sleep pc[15:0]}
    localparam logic [18:0] VECS [NV] = '{
        {2'b01, 1'b1, 16'h0100},
        {2'b01, 1'b0, 16'h0200},
        {2'b11, 1'b1, 16'h0300},
        {2'b11, 1'b0, 16'h0420},
        {2'b00, 1'b0, 16'h0050},
        {2'b10, 1'b1, 16'h07F0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic [AW-1:0] pc_in = '0;
    logic          int_pin = 1'b0;
    logic [1:0]    osc_mode = 2'b01;
    logic          gie_we = 1'b0;
    logic          gie_wdata = 1'b0;
    logic          flag_clr = 1'b0;
    logic          fetch_valid;
    logic [AW-1:0] fetch_addr;
    logic          flush;
    logic          int_flag;
    logic          gie;
    logic          core_halt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    slpw_wake_ctrl #(.AW(AW), .OST_LEN(OST)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .pc_in       (pc_in),
        .int_pin     (int_pin),
        .osc_mode    (osc_mode),
        .gie_we      (gie_we),
        .gie_wdata   (gie_wdata),
        .flag_clr    (flag_clr),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .flush       (flush),
        .int_flag    (int_flag),
        .gie         (gie),
        .core_halt   (core_halt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run_wake(input logic [1:0] mode, input logic g, input logic [15:0] pc);
        int  d;
        bit  early;
        string tg;
        d  = (mode == 2'b11) ? 4 : OST + 4;
        tg = (mode == 2'b11) ? "R3 slot timing" : "R2 slot timing";
        @(negedge clk);
        flag_clr = 1'b1; gie_we = 1'b1; gie_wdata = g; osc_mode = mode;
        @(negedge clk);
        flag_clr = 1'b0; gie_we = 1'b0;
        chk("R10 gie written", gie, g);
        chk("R1 flag cleared", int_flag, 0);
        sleep_req = 1'b1; pc_in = pc;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R9 halt after sleep", core_halt, 1);
        early = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (fetch_valid || flush) early = 1'b1;
        end
        chk("R9 no slots while asleep", early, 0);
        int_pin = 1'b1;
        @(negedge clk);
        chk("R1 flag on edge", int_flag, 1);
        if (mode != 2'b11) chk("R2 halted during startup", core_halt, 1);
        early = 1'b0;
        for (int n = 1; n < d; n++) begin
            @(negedge clk);
            if (fetch_valid || flush) early = 1'b1;
            if (n == 2) int_pin = 1'b0;
        end
        chk({tg, " nothing early"}, early, 0);
        @(negedge clk);
        chk("R2 halt released", core_halt, 0);
        if (g) begin
            chk({tg, " R4 flush slot"}, flush, 1);
            chk("R4 no fetch in flush slot", fetch_valid, 0);
            chk("R6 gie cleared on vector", gie, 0);
            repeat (4) @(negedge clk);
            chk("R4 vector fetch valid", fetch_valid, 1);
            chk("R4 vector address", fetch_addr, 16'h0008);
            repeat (4) @(negedge clk);
            chk("R4 vector+2 address", {fetch_valid, fetch_addr}, {1'b1, 16'h000A});
        end else begin
            chk({tg, " R5 fetch slot"}, fetch_valid, 1);
            chk("R5 no flush in-line", flush, 0);
            chk("R5 in-line address", fetch_addr, pc + 16'd4);
            chk("R6 gie unchanged in-line", gie, 0);
            repeat (4) @(negedge clk);
            chk("R5 next in-line address", {fetch_valid, fetch_addr}, {1'b1, pc + 16'd6});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R9 reset halt", core_halt, 0);
        chk("R7 reset fetch", fetch_valid, 0);
        chk("R4 reset flush", flush, 0);
        chk("R1 reset flag", int_flag, 0);
        chk("R10 reset gie", gie, 0);

        // R7 cadence while running
        seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            if (fetch_valid) seen = 1'b1;
        end
        chk("R7 fetch seen", seen, 1);
        a = fetch_addr;
        @(negedge clk);
        chk("R7 one clock pulse", fetch_valid, 0);
        repeat (3) @(negedge clk);
        chk("R7 next fetch", {fetch_valid, fetch_addr}, {1'b1, a + 16'd2});

        // table of wake-up scenarios
        for (int v = 0; v < NV; v++) begin
            run_wake(VECS[v][18:17], VECS[v][16], VECS[v][15:0]);
        end

        // R8: edge while running does not stall, then sleep is refused
        @(negedge clk);
        int_pin = 1'b1;
        @(negedge clk);
        int_pin = 1'b0;
        chk("R8 running edge sets flag", int_flag, 1);
        chk("R8 running edge no halt", core_halt, 0);
        sleep_req = 1'b1; pc_in = 16'h0900;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R8 sleep refused with flag", core_halt, 0);
        seen = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (fetch_valid) seen = 1'b1;
        end
        chk("R8 fetching continues", seen, 1);
        chk("R1 flag held", int_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk("R1 flag cleared by software", int_flag, 0);

        // R8: edge in the same clock as the sleep request
        sleep_req = 1'b1; pc_in = 16'h0A00; int_pin = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; int_pin = 1'b0;
        chk("R8 same-clock edge blocks sleep", core_halt, 0);
        chk("R8 same-clock edge sets flag", int_flag, 1);

        // R1: edge together with clear keeps the flag
        @(negedge clk);
        flag_clr = 1'b1; int_pin = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; int_pin = 1'b0;
        chk("R1 set beats clear", int_flag, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule